// File: doc/BRIEF.md
# Dual Mode-Selectable Timer/Counter

This block holds two 16-bit timer/counters, each stored as a high byte and a low byte. An 8-bit mode register configures both timers, and a control register holds one run bit and one overflow flag per timer. Each timer counts machine-cycle ticks or falling edges on its own external count pin. It can also be gated by its own gate pin. Each timer has four mode bits, and the selected counting mode sets the counter width and what happens on overflow.

A machine cycle lasts `CYC_DIV` clocks, 12 by default, and one internal tick is produced per machine cycle. The count pins are sampled once per tick. A count event is a sample of 1 followed by a sample of 0 at the next tick, so external events can be counted at most once every two machine cycles.

Software uses a single write port and a combinational read port. The interrupt logic clears a flag through a per-timer acknowledge input when it services that timer.

Top module: `twin_tmr`

## Requirements
- R1: After reset, every register reads 0 and both overflow flags are 0.
- R2: A write to address 0 (timer 0 low byte), 1 (timer 0 high byte), 2 (timer 1 low byte), 3 (timer 1 high byte) or 4 (mode register) reads back at that address from the next cycle. A write to a byte takes precedence over a count in the same cycle.
- R3: Timer bit 2 = 0 selects counting internal ticks. A tick occurs on every `CYC_DIV`-th clock after reset and never between ticks.
- R4: Timer bit 3 = 1 (gate) lets a running timer count only while its gate pin is high. With bit 3 = 0, the run bit alone enables counting.
- R5: Timer bit 2 = 1 counts one event each time the count pin is sampled as 1 at one tick and as 0 at the next tick.
- R6: Mode 0 (bits 1:0 = 0) is a 13-bit counter formed by the high byte above low bits 4:0. Low bits 7:5 hold their value, and the counter wraps from 0x1FFF to 0 with an overflow.
- R7: Mode 1 is a 16-bit counter that wraps from 0xFFFF to 0 and sets that timer's flag.
- R8: In mode 2 the low byte counts. When it overflows from 0xFF it is reloaded from the high byte, which is left unchanged, and the flag is set.
- R9: With timer 0 in mode 3, its low byte is an 8-bit counter under timer 0's controls that sets flag 0. Its high byte counts ticks whenever run bit 1 is set and sets flag 1. Timer 1 keeps counting but no longer sets flag 1. Timer 1 in mode 3 holds its value.
- R10: Acknowledge bit i clears flag i, but an overflow in the same cycle leaves the flag set. A control-register write overrides both.
- R11: Address 5 is control: bit 0 is run 0, bit 1 is run 1, bit 4 is flag 0 and bit 5 is flag 1. All other bits read 0. The mode register holds timer 0 in bits 3:0 and timer 1 in bits 7:4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Write address |
| wr_data | input | 8 | Write data |
| rd_addr | input | 3 | Read address |
| rd_data | output | 8 | Read data, combinational from the addressed register |
| cnt_pin | input | 2 | External count inputs, bit i for timer i |
| gate_pin | input | 2 | Gate inputs, bit i for timer i |
| ack_clr | input | 2 | Flag clear on interrupt service, bit i for timer i |
| ovf_flag | output | 2 | Overflow flags, bit i for timer i |

## Verification
Register writes and acknowledges take effect at the clock edge after they are presented, so the result shows on `rd_data` and `ovf_flag` one cycle later. Counts take effect only at the edge where the tick is active, which is one edge in every `CYC_DIV`. An external event needs two ticks: the 1 sample and then the 0 sample.

The bench runs its own prescaler and pin-sample model from the moment reset is released. It predicts the state after each edge and compares every register and flag at the following falling edge. This way every count is checked in the exact cycle it must appear, and no count may appear in any other cycle.

// File: rtl/twin_tmr_pkg.sv
package twin_tmr_pkg;

    localparam int BYTE_W = 8;
    localparam int ADDR_W = 3;
    localparam int NUM_TMR = 2;

    typedef enum logic [ADDR_W-1:0] {
        A_T0LO = 3'd0,
        A_T0HI = 3'd1,
        A_T1LO = 3'd2,
        A_T1HI = 3'd3,
        A_MODE = 3'd4,
        A_CTRL = 3'd5
    } reg_addr_e;

    typedef struct packed {
        logic [BYTE_W-1:0] hi;
        logic [BYTE_W-1:0] lo;
    } tmr_t;

    typedef struct packed {
        tmr_t [NUM_TMR-1:0]   t;
        logic [BYTE_W-1:0]    mode;
        logic [NUM_TMR-1:0]   run;
        logic [NUM_TMR-1:0]   flag;
    } state_t;

    typedef struct packed {
        tmr_t v;
        logic ovf;
    } step_t;

    // One count step of a timer in counting mode md.
    function automatic step_t tmr_step(tmr_t cur, logic [1:0] md);
        step_t r;
        logic [13:0] w13;
        logic [16:0] w16;
        logic [8:0]  w8;
        r = '{v: cur, ovf: 1'b0};
        case (md)
            2'd0: begin
                w13 = {1'b0, cur.hi, cur.lo[4:0]} + 14'd1;
                r.v.hi = w13[12:5];
                r.v.lo = {cur.lo[7:5], w13[4:0]};
                r.ovf  = w13[13];
            end
            2'd1: begin
                w16 = {1'b0, cur.hi, cur.lo} + 17'd1;
                r.v   = w16[15:0];
                r.ovf = w16[16];
            end
            2'd2: begin
                if (cur.lo == 8'hFF) begin
                    r.v.lo = cur.hi;
                    r.ovf  = 1'b1;
                end else begin
                    r.v.lo = cur.lo + 8'd1;
                end
            end
            default: begin
                w8 = {1'b0, cur.lo} + 9'd1;
                r.v.lo = w8[7:0];
                r.ovf  = w8[8];
            end
        endcase
        return r;
    endfunction

endpackage

// File: rtl/tmr_tick_gen.sv
module tmr_tick_gen #(
    parameter int DIV = 12
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick
);
    localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        tick  = (cnt_q == CW'(DIV - 1));
        cnt_d = tick ? '0 : cnt_q + CW'(1);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end
endmodule

// File: rtl/tmr_fall_det.sv
module tmr_fall_det (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic pin,
    output logic evt
);
    logic smp_d, smp_q;

    always_comb begin
        evt   = tick && smp_q && !pin;
        smp_d = tick ? pin : smp_q;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) smp_q <= 1'b0;
        else        smp_q <= smp_d;
    end
endmodule

// File: rtl/twin_tmr.sv
module twin_tmr
    import twin_tmr_pkg::*;
#(
    parameter int CYC_DIV = 12
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_en,
    input  logic [ADDR_W-1:0]    wr_addr,
    input  logic [BYTE_W-1:0]    wr_data,
    input  logic [ADDR_W-1:0]    rd_addr,
    output logic [BYTE_W-1:0]    rd_data,
    input  logic [NUM_TMR-1:0]   cnt_pin,
    input  logic [NUM_TMR-1:0]   gate_pin,
    input  logic [NUM_TMR-1:0]   ack_clr,
    output logic [NUM_TMR-1:0]   ovf_flag
);
    state_t st_d, st_q;
    logic tick;
    logic [NUM_TMR-1:0] evt, inc, set;
    logic [1:0] md0, md1;
    step_t s0, s1;
    logic [8:0] hi_w;

    tmr_tick_gen #(.DIV(CYC_DIV)) u_tick (.clk(clk), .rst_n(rst_n), .tick(tick));

    for (genvar g = 0; g < NUM_TMR; g++) begin : g_edge
        tmr_fall_det u_det (
            .clk(clk), .rst_n(rst_n), .tick(tick),
            .pin(cnt_pin[g]), .evt(evt[g])
        );
    end

    always_comb begin
        st_d = st_q;
        set  = '0;
        md0  = st_q.mode[1:0];
        md1  = st_q.mode[5:4];
        for (int i = 0; i < NUM_TMR; i++) begin
            inc[i] = st_q.run[i]
                  && (!st_q.mode[4*i+3] || gate_pin[i])
                  && (st_q.mode[4*i+2] ? evt[i] : tick);
        end

        // timer 0 (low byte only when split)
        s0 = tmr_step(st_q.t[0], md0);
        if (inc[0]) begin
            st_d.t[0] = s0.v;
            set[0]    = s0.ovf;
        end

        // split mode: high byte of timer 0 runs on run bit 1
        hi_w = {1'b0, st_q.t[0].hi} + 9'd1;
        if (md0 == 2'd3 && st_q.run[1] && tick) begin
            st_d.t[0].hi = hi_w[7:0];
            set[1]       = hi_w[8];
        end

        // timer 1, halted in mode 3
        s1 = tmr_step(st_q.t[1], md1);
        if (inc[1] && md1 != 2'd3) begin
            st_d.t[1] = s1.v;
            if (md0 != 2'd3) set[1] = s1.ovf;
        end

        st_d.flag = (st_q.flag & ~ack_clr) | set;

        if (wr_en) begin
            case (wr_addr)
                A_T0LO: st_d.t[0].lo = wr_data;
                A_T0HI: st_d.t[0].hi = wr_data;
                A_T1LO: st_d.t[1].lo = wr_data;
                A_T1HI: st_d.t[1].hi = wr_data;
                A_MODE: st_d.mode    = wr_data;
                A_CTRL: begin
                    st_d.run  = wr_data[1:0];
                    st_d.flag = wr_data[5:4];
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_comb begin
        case (rd_addr)
            A_T0LO:  rd_data = st_q.t[0].lo;
            A_T0HI:  rd_data = st_q.t[0].hi;
            A_T1LO:  rd_data = st_q.t[1].lo;
            A_T1HI:  rd_data = st_q.t[1].hi;
            A_MODE:  rd_data = st_q.mode;
            A_CTRL:  rd_data = {2'b00, st_q.flag, 2'b00, st_q.run};
            default: rd_data = '0;
        endcase
    end

    assign ovf_flag = st_q.flag;
endmodule

// File: rtl/twin_tmr_chk.sv
module twin_tmr_chk
    import twin_tmr_pkg::*;
(
    input logic               clk,
    input logic               rst_n,
    input logic               wr_en,
    input logic [ADDR_W-1:0]  wr_addr,
    input logic [BYTE_W-1:0]  wr_data,
    input logic [NUM_TMR-1:0] gate_pin,
    input logic [NUM_TMR-1:0] ack_clr,
    input logic [NUM_TMR-1:0] ovf_flag,
    input logic               tick,
    input state_t             st_q
);
    AST_MODE_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == A_MODE) |=> st_q.mode == $past(wr_data)); // R2

    AST_CTRL_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == A_CTRL) |=> ovf_flag == $past(wr_data[5:4])); // R10

    AST_NO_COUNT_OFF_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick && !(wr_en && (wr_addr == A_T0LO || wr_addr == A_T0HI)))
        |=> $stable(st_q.t[0])); // R3

    AST_GATE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.mode[3] && !gate_pin[0] && !(wr_en && wr_addr == A_T0LO))
        |=> $stable(st_q.t[0].lo)); // R4

    AST_SPLIT_T1_HALT: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.mode[5:4] == 2'd3 && !(wr_en && (wr_addr == A_T1LO || wr_addr == A_T1HI)))
        |=> $stable(st_q.t[1])); // R9

    AST_ACK_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_clr[0] && !tick && !(wr_en && wr_addr == A_CTRL)) |=> !ovf_flag[0]); // R10
endmodule

bind twin_tmr twin_tmr_chk chk_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .gate_pin(gate_pin), .ack_clr(ack_clr),
    .ovf_flag(ovf_flag), .tick(tick), .st_q(st_q)
);

// File: tb/twin_tmr_tb_top.sv
module twin_tmr_tb_top;
    localparam int DIV = 12;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic wr_en = 1'b0;
    logic [2:0] wr_addr = '0;
    logic [7:0] wr_data = '0;
    logic [2:0] rd_addr = '0;
    logic [7:0] rd_data;
    logic [1:0] cnt_pin = '0;
    logic [1:0] gate_pin = '0;
    logic [1:0] ack_clr = '0;
    logic [1:0] ovf_flag;

    int checks = 0;
    int failures = 0;
    int rr = 0;
    bit done = 0;

    // reference model
    logic [7:0] m_lo [2];
    logic [7:0] m_hi [2];
    logic [7:0] m_mode;
    logic [1:0] m_run, m_flag, m_smp;
    int m_div;

    always #10 clk = ~clk; // 50 MHz

    twin_tmr #(.CYC_DIV(DIV)) dut_i (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
        .cnt_pin(cnt_pin), .gate_pin(gate_pin), .ack_clr(ack_clr),
        .ovf_flag(ovf_flag)
    );

    function automatic logic [7:0] model_rd(logic [2:0] a);
        case (a)
            3'd0: return m_lo[0];
            3'd1: return m_hi[0];
            3'd2: return m_lo[1];
            3'd3: return m_hi[1];
            3'd4: return m_mode;
            3'd5: return {2'b00, m_flag, 2'b00, m_run};
            default: return 8'h00;
        endcase
    endfunction

    task automatic check(input string tag, input string what, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s %s actual=%02h expected=%02h", tag, what, act, exp);
        end
    endtask

    // One clock: predict the next state from the driven inputs, then compare.
    task automatic cycle(input string tag);
        logic tk, ovf;
        logic [1:0] ev, inc, set, nrun, nflag, md0, md1, md;
        logic [7:0] nlo [2];
        logic [7:0] nhi [2];
        logic [7:0] nmode;
        logic [12:0] v13;
        logic [15:0] v16;
        rd_addr = 3'(rr % 6);
        rr++;
        tk = (m_div == DIV - 1);
        md0 = m_mode[1:0];
        md1 = m_mode[5:4];
        nlo = m_lo; nhi = m_hi; set = '0;
        for (int i = 0; i < 2; i++) begin
            ev[i] = tk && m_smp[i] && !cnt_pin[i];
            inc[i] = m_run[i] && (!m_mode[4*i+3] || gate_pin[i]) && (m_mode[4*i+2] ? ev[i] : tk);
        end
        for (int i = 0; i < 2; i++) begin
            md = (i == 0) ? md0 : md1;
            ovf = 1'b0;
            if (inc[i] && !(i == 1 && md1 == 2'd3)) begin
                case (md)
                    2'd0: begin
                        v13 = {m_hi[i], m_lo[i][4:0]};
                        ovf = (v13 == 13'h1FFF);
                        v13 = v13 + 13'd1;
                        nhi[i] = v13[12:5];
                        nlo[i] = {m_lo[i][7:5], v13[4:0]};
                    end
                    2'd1: begin
                        v16 = {m_hi[i], m_lo[i]};
                        ovf = (v16 == 16'hFFFF);
                        v16 = v16 + 16'd1;
                        nhi[i] = v16[15:8];
                        nlo[i] = v16[7:0];
                    end
                    2'd2: begin
                        ovf = (m_lo[i] == 8'hFF);
                        nlo[i] = ovf ? m_hi[i] : m_lo[i] + 8'd1;
                    end
                    default: begin
                        ovf = (m_lo[i] == 8'hFF);
                        nlo[i] = m_lo[i] + 8'd1;
                    end
                endcase
                if (ovf && (i == 0 || md0 != 2'd3)) set[i] = 1'b1;
            end
        end
        if (md0 == 2'd3 && m_run[1] && tk) begin
            if (m_hi[0] == 8'hFF) set[1] = 1'b1;
            nhi[0] = m_hi[0] + 8'd1;
        end
        nflag = (m_flag & ~ack_clr) | set;
        nrun = m_run;
        nmode = m_mode;
        if (wr_en) begin
            case (wr_addr)
                3'd0: nlo[0] = wr_data;
                3'd1: nhi[0] = wr_data;
                3'd2: nlo[1] = wr_data;
                3'd3: nhi[1] = wr_data;
                3'd4: nmode = wr_data;
                3'd5: begin nrun = wr_data[1:0]; nflag = wr_data[5:4]; end
                default: ;
            endcase
        end
        @(posedge clk);
        @(negedge clk);
        m_lo = nlo; m_hi = nhi; m_mode = nmode; m_run = nrun; m_flag = nflag;
        if (tk) m_smp = cnt_pin;
        m_div = tk ? 0 : m_div + 1;
        check(tag, "rd_data", rd_data, model_rd(rd_addr));
        check(tag, "ovf_flag", {6'd0, ovf_flag}, {6'd0, m_flag});
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] d, input string tag);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        cycle(tag);
        wr_en = 1'b0;
    endtask

    task automatic idle(input int n, input string tag);
        for (int k = 0; k < n; k++) cycle(tag);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog (all requirements) actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd4721));
        for (int i = 0; i < 2; i++) begin m_lo[i] = '0; m_hi[i] = '0; end
        m_mode = '0; m_run = '0; m_flag = '0; m_smp = '0; m_div = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        for (int a = 0; a < 6; a++) begin
            rd_addr = 3'(a);
            #1 check("R1", "reset read", rd_data, 8'h00);
        end
        rst_n = 1'b1;
        idle(6, "R1");

        // R2: byte and mode writes read back
        wr(3'd0, 8'h5A, "R2"); wr(3'd1, 8'hA5, "R2");
        wr(3'd2, 8'h3C, "R2"); wr(3'd3, 8'hC3, "R2");
        wr(3'd4, 8'h96, "R2");
        idle(6, "R2");
        // R11: control layout
        wr(3'd5, 8'hFF, "R11");
        rd_addr = 3'd5;
        #1 check("R11", "ctrl read", rd_data, 8'h33);
        wr(3'd5, 8'h00, "R11");
        wr(3'd4, 8'h00, "R11");

        // R3 / R7: timer mode, 16-bit, overflow
        wr(3'd4, 8'h01, "R3");
        wr(3'd0, 8'hF0, "R3"); wr(3'd1, 8'hFF, "R3");
        wr(3'd5, 8'h01, "R3");
        idle(120, "R3");
        idle(120, "R7");
        // R10: acknowledge clears flag
        ack_clr = 2'b01; cycle("R10"); ack_clr = 2'b00;
        idle(4, "R10");
        // R10: control write beats an overflow in the same cycle
        wr(3'd0, 8'hFF, "R10"); wr(3'd1, 8'hFF, "R10");
        for (int k = 0; k < 30; k++) wr(3'd5, 8'h01, "R10");
        // ack held across an overflow: set wins
        wr(3'd0, 8'hFE, "R10");
        ack_clr = 2'b01; idle(30, "R10"); ack_clr = 2'b00;

        // R4: gating
        wr(3'd4, 8'h99, "R4");
        wr(3'd5, 8'h03, "R4");
        for (int k = 0; k < 300; k++) begin
            gate_pin = 2'($urandom);
            if (k % 40 < 20) gate_pin = 2'b00;
            cycle("R4");
        end

        // R5: event counting
        wr(3'd4, 8'h55, "R5");
        wr(3'd0, 8'hF8, "R5"); wr(3'd1, 8'hFF, "R5");
        for (int k = 0; k < 400; k++) begin
            if (k % 12 == 0) cnt_pin = ~cnt_pin;
            cycle("R5");
        end
        for (int k = 0; k < 300; k++) begin
            cnt_pin = 2'($urandom);
            cycle("R5");
        end

        // R6: 13-bit mode with upper low bits held
        wr(3'd4, 8'h00, "R6");
        wr(3'd0, 8'hBC, "R6"); wr(3'd1, 8'hFF, "R6");
        wr(3'd5, 8'h01, "R6");
        idle(80, "R6");

        // R8: auto-reload on both timers
        wr(3'd4, 8'h22, "R8");
        wr(3'd0, 8'hFD, "R8"); wr(3'd1, 8'hF0, "R8");
        wr(3'd2, 8'hFE, "R8"); wr(3'd3, 8'hF8, "R8");
        wr(3'd5, 8'h03, "R8");
        idle(400, "R8");

        // R9: split timer 0, timer 1 counting without flag, then halted
        wr(3'd4, 8'h13, "R9");
        wr(3'd5, 8'h00, "R9");
        wr(3'd0, 8'hFC, "R9"); wr(3'd1, 8'hFD, "R9");
        wr(3'd2, 8'hF0, "R9"); wr(3'd3, 8'hFF, "R9");
        wr(3'd5, 8'h03, "R9");
        idle(300, "R9");
        wr(3'd4, 8'h33, "R9");
        idle(100, "R9");

        // mixed random traffic, still scored against the model
        for (int k = 0; k < 5000; k++) begin
            wr_en = ($urandom % 5 == 0);
            wr_addr = 3'($urandom % 6);
            wr_data = 8'($urandom);
            cnt_pin = 2'($urandom);
            gate_pin = 2'($urandom);
            ack_clr = ($urandom % 8 == 0) ? 2'($urandom) : 2'b00;
            cycle("R2");
        end
        wr_en = 1'b0; ack_clr = '0;

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule